// File: doc/BRIEF.md
# Banked Interrupt Mask and Status Controller

This block gathers a set of already-conditioned, active-high interrupt requests, grouped into equal banks of one bus word each, and turns them into a single registered interrupt line for a parent processor. Each line has an enable bit and a software-forced request bit. Software reads a raw view (hardware request OR forced request) and a masked view (raw AND enable) of every bank. When the parent interrupt fires, software scans the masked words and finds the sources itself.

Enable and forced-request bits are never written directly. Each has a set register and a clear register, and a write changes only the bits written as one. Software therefore never needs a read-modify-write sequence. Each bank occupies six consecutive words, and bank `b` starts at byte offset `b * 0x18`. With the default parameters the low bank (lines 0..31) sits at 0x00 and the high bank (lines 32..63) sits at 0x18. The normal start-up step is to write all ones to each bank's enable-clear register.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit and every forced-request bit is zero, `irq_o` is low, and every mapped register reads zero while no request is active.
- R2: Bank `b` starts at byte address `b*0x18`. Word offsets within a bank are: 0x00 masked status, 0x04 raw status, 0x08 enable-set, 0x0C enable-clear, 0x10 soft-set, 0x14 soft-clear. Reads of unmapped addresses (at or above `NUM_BANKS*0x18`) and of addresses not aligned to a word return zero.
- R3: A write to enable-set ORs the written word into that bank's enable bits. Bits written as zero keep their value.
- R4: A write to enable-clear clears exactly the enable bits written as one. Writing all ones disables every line of that bank.
- R5: Writes to soft-set and soft-clear set or clear exactly the forced-request bits written as one.
- R6: Raw status of a bank is the bitwise OR of its hardware request inputs and its forced-request bits.
- R7: Masked status of a bank is its raw status ANDed with its enable bits. A request on a disabled line does not raise `irq_o`.
- R8: Reading enable-set or enable-clear returns the current enable bits. Reading soft-set or soft-clear returns the current forced-request bits.
- R9: `irq_o` is registered. It equals the OR of all masked status bits of every bank as they stood one clock earlier.
- R10: Writes to the status offsets, to unmapped addresses and to misaligned addresses change no state.
- R11: Read data appears on `bus_rdata_o` on the clock edge that follows the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_BANKS*BANK_W | Conditioned hardware requests; line `n` sits in bank `n/BANK_W` |
| bus_req_i | input | 1 | Bus access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | BANK_W | Write data |
| bus_rdata_o | output | BANK_W | Registered read data |
| irq_o | output | 1 | Combined interrupt to the parent |

## Verification
The bench builds the block with its defaults: two banks of 32 lines and an 8-bit address. This places both bank bases and the unmapped space above 0x30 inside one address byte. The high bank tests the bank-stride decode and its contribution to the combined output, independent of the low bank. The 8-bit address also allows misaligned offsets that alias onto live registers, so the bench can confirm that writes to them are dropped.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // Word index within a bank; order is the address map.
  typedef enum logic [2:0] {
    SEL_MASKED   = 3'd0,
    SEL_RAW      = 3'd1,
    SEL_EN_SET   = 3'd2,
    SEL_EN_CLR   = 3'd3,
    SEL_SOFT_SET = 3'd4,
    SEL_SOFT_CLR = 3'd5
  } reg_sel_e;

  localparam int unsigned REGS_PER_BANK = 6;
  localparam int unsigned BANK_STRIDE_B = REGS_PER_BANK * 4;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BANK_IDX_W = 1
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  valid_o,
  output logic [BANK_IDX_W-1:0] bank_o,
  output reg_sel_e              sel_o
);
  logic [ADDR_W-3:0] word;
  logic [31:0]       bank_full;

  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    bank_full = 32'(word) / 32'(REGS_PER_BANK);
    valid_o   = (bank_full < 32'(NUM_BANKS)) && (addr_i[1:0] == 2'b00);
    bank_o    = BANK_IDX_W'(bank_full);
    sel_o     = reg_sel_e'(3'(32'(word) % 32'(REGS_PER_BANK)));
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] req_i,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] soft_o,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] masked_o
);
  logic [BANK_W-1:0] en_q, soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      soft_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_EN_SET:   en_q   <= en_q | wdata_i;
        SEL_EN_CLR:   en_q   <= en_q & ~wdata_i;
        SEL_SOFT_SET: soft_q <= soft_q | wdata_i;
        SEL_SOFT_CLR: soft_q <= soft_q & ~wdata_i;
        default: ;  // status words are read-only
      endcase
    end
  end

  assign en_o     = en_q;
  assign soft_o   = soft_q;
  assign raw_o    = req_i | soft_q;
  assign masked_o = raw_o & en_q;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_LINES  = NUM_BANKS * BANK_W,
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [BANK_W-1:0]    bus_wdata_i,
  output logic [BANK_W-1:0]    bus_rdata_o,
  output logic                 irq_o
);
  logic                  dec_valid;
  logic [BANK_IDX_W-1:0] dec_bank;
  reg_sel_e              dec_sel;

  logic [BANK_W-1:0] en_b     [NUM_BANKS];
  logic [BANK_W-1:0] soft_b   [NUM_BANKS];
  logic [BANK_W-1:0] raw_b    [NUM_BANKS];
  logic [BANK_W-1:0] masked_b [NUM_BANKS];

  logic [NUM_LINES-1:0] en_all, soft_all, masked_all;
  logic [BANK_W-1:0]    rd_val, rdata_q;
  logic                 irq_q;

  irq_addr_dec #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_IDX_W(BANK_IDX_W)
  ) u_dec (
    .addr_i (bus_addr_i),
    .valid_o(dec_valid),
    .bank_o (dec_bank),
    .sel_o  (dec_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_en;
    assign wr_en = bus_req_i && bus_we_i && dec_valid && (dec_bank == BANK_IDX_W'(b));

    irq_bank #(.BANK_W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (irq_i[b*BANK_W +: BANK_W]),
      .wr_en_i (wr_en),
      .wr_sel_i(dec_sel),
      .wdata_i (bus_wdata_i),
      .en_o    (en_b[b]),
      .soft_o  (soft_b[b]),
      .raw_o   (raw_b[b]),
      .masked_o(masked_b[b])
    );

    assign en_all[b*BANK_W +: BANK_W]     = en_b[b];
    assign soft_all[b*BANK_W +: BANK_W]   = soft_b[b];
    assign masked_all[b*BANK_W +: BANK_W] = masked_b[b];
  end

  always_comb begin
    rd_val = '0;
    if (dec_valid) begin
      unique case (dec_sel)
        SEL_MASKED:                 rd_val = masked_b[dec_bank];
        SEL_RAW:                    rd_val = raw_b[dec_bank];
        SEL_EN_SET, SEL_EN_CLR:     rd_val = en_b[dec_bank];
        SEL_SOFT_SET, SEL_SOFT_CLR: rd_val = soft_b[dec_bank];
        default:                    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_req_i && !bus_we_i) rdata_q <= rd_val;
      irq_q <= |masked_all;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_i,
  input logic                 bus_req_i,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [BANK_W-1:0]    bus_wdata_i,
  input logic [BANK_W-1:0]    bus_rdata_o,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] en_all,
  input logic [NUM_LINES-1:0] soft_all
);
  logic wr, rd;
  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;

  a_r9_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|((irq_i | soft_all) & en_all)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(b * 24);

    a_r3_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && bus_addr_i == BASE + ADDR_W'(8)
      |=> en_all[b*BANK_W +: BANK_W] == $past(en_all[b*BANK_W +: BANK_W] | bus_wdata_i));

    a_r4_en_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && bus_addr_i == BASE + ADDR_W'(12)
      |=> en_all[b*BANK_W +: BANK_W] == $past(en_all[b*BANK_W +: BANK_W] & ~bus_wdata_i));

    a_r5_soft_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && bus_addr_i == BASE + ADDR_W'(16)
      |=> soft_all[b*BANK_W +: BANK_W] == $past(soft_all[b*BANK_W +: BANK_W] | bus_wdata_i));

    a_r10_status_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && (bus_addr_i == BASE || bus_addr_i == BASE + ADDR_W'(4))
      |=> $stable(en_all) && $stable(soft_all));

    a_r11_read_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd && bus_addr_i == BASE + ADDR_W'(8)
      |=> bus_rdata_o == $past(en_all[b*BANK_W +: BANK_W]));
  end

  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata_o));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .en_all     (en_all),
  .soft_all   (soft_all)
);

// File: tb/irq_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb_top;
  localparam int NB = 2, BW = 32, AW = 8;
  localparam realtime TCK = 8.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   irq = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic          irq_out;

  int checks = 0, errors = 0;
  logic [BW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_flag = 1'b0;

  always #(TCK/2) clk = ~clk;

  irq_bank_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: one access per call, starting and ending on a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [BW-1:0] exp, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); req = 1'b0;
  endtask

  // Monitor: R11 read data is due on the edge after the request.
  always @(posedge clk) rd_flag <= req && !we;
  always @(negedge clk) begin
    if (rd_flag) begin
      if (exp_q.size() == 0) check("R11 unexpected read data", rdata, 'x);
      else check({tag_q.pop_front(), " R11"}, rdata, exp_q.pop_front());
    end
  end

  task automatic chk_irq(input string tag, input logic exp);
    check(tag, {31'd0, irq_out}, {31'd0, exp});
  endtask

  initial begin
    #(TCK * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_irq("R1 irq_o in reset", 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) rd(AW'(i * 4), '0, "R1 reset value");
    chk_irq("R1 irq_o after reset", 1'b0);

    wr(8'h0C, '1); wr(8'h24, '1);
    rd(8'h08, '0, "R4 clear all lo"); rd(8'h20, '0, "R4 clear all hi");

    wr(8'h08, 32'h0000_00F0);
    rd(8'h08, 32'h0000_00F0, "R3 enable set");
    rd(8'h0C, 32'h0000_00F0, "R8 enable via clear addr");
    wr(8'h08, 32'h0000_0003);
    rd(8'h08, 32'h0000_00F3, "R3 set keeps zeros");
    wr(8'h0C, 32'h0000_0002);
    rd(8'h0C, 32'h0000_00F1, "R4 clear only ones");

    // Disabled line: raw shows it, masked and irq_o do not.
    @(negedge clk); irq[8] = 1'b1;
    repeat (2) @(negedge clk);
    chk_irq("R7 disabled line no irq", 1'b0);
    rd(8'h04, 32'h0000_0100, "R6 raw hw");
    rd(8'h00, 32'h0000_0000, "R7 masked disabled");

    // Enabled line: irq_o lags one edge.
    @(negedge clk); irq[4] = 1'b1;
    #1 chk_irq("R9 not before edge", 1'b0);
    @(negedge clk); chk_irq("R9 rise one cycle later", 1'b1);
    rd(8'h00, 32'h0000_0010, "R7 masked enabled");
    @(negedge clk); irq = '0;
    @(negedge clk); chk_irq("R9 fall one cycle later", 1'b0);

    // High bank soft requests.
    wr(8'h28, 32'h8000_0001);
    rd(8'h28, 32'h8000_0001, "R5 soft set hi");
    rd(8'h2C, 32'h8000_0001, "R8 soft via clear addr");
    rd(8'h1C, 32'h8000_0001, "R6 raw soft");
    rd(8'h18, 32'h0000_0000, "R7 masked soft disabled");
    chk_irq("R7 soft disabled no irq", 1'b0);
    @(negedge clk); irq[39:32] = 8'hA5;
    rd(8'h1C, 32'h8000_00A5, "R6 raw hw or soft");
    @(negedge clk); irq = '0;

    wr(8'h20, 32'h8000_0000);
    chk_irq("R9 hi bank not yet", 1'b0);
    @(negedge clk); chk_irq("R9 hi bank raises irq", 1'b1);
    rd(8'h18, 32'h8000_0000, "R7 masked hi");
    wr(8'h2C, 32'h8000_0000);
    @(negedge clk); chk_irq("R9 soft clear drops irq", 1'b0);
    rd(8'h28, 32'h0000_0001, "R5 soft clear only ones");
    wr(8'h2C, '1);
    rd(8'h28, '0, "R5 soft clear all");

    // Ignored writes.
    wr(8'h00, '1); wr(8'h04, '1); wr(8'h18, '1); wr(8'h30, '1); wr(8'h09, '1); wr(8'h11, '1);
    rd(8'h08, 32'h0000_00F1, "R10 lo enable unchanged");
    rd(8'h10, '0, "R10 lo soft unchanged");
    rd(8'h20, 32'h8000_0000, "R10 hi enable unchanged");
    rd(8'h28, '0, "R10 hi soft unchanged");
    chk_irq("R10 irq stays low", 1'b0);

    rd(8'h30, '0, "R2 unmapped read");
    rd(8'hFC, '0, "R2 top of space read");
    rd(8'h0A, '0, "R2 misaligned read");
    rd(8'h20, 32'h8000_0000, "R2 hi bank base plus 8");

    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule